// File: doc/BRIEF.md
# Eight-Line Priority Interrupt Controller

This block takes eight level-sensitive request lines and reports the most urgent one to a host processor. Line 0 is the most urgent and line 7 the least. The block keeps three 8-bit registers: the pending requests, the levels now being serviced, and a mask. The host reaches them through a byte-wide port with a single address bit, which selects an even and an odd location.

The host first programs the block with a short sequence of configuration bytes. After that it uses command bytes to mask lines, to end the service of a level, to choose which status register a read of the even location returns, and to arm a poll. The read that follows a poll command returns the winning level and acknowledges it. There is no bus vector cycle. If no request qualifies at the poll read, the block reports level 7 with the valid flag clear and marks nothing in service. The host sees the spurious case this way.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset the mask reads 0xFF, the request and in-service registers read 0x00, `int_out` is low, and the command decoder is ready, so an odd write loads the mask at once.
- R2: An even write with bit 4 set starts configuration. It clears the in-service register, cancels an armed poll and selects request readback. The next two odd writes, plus a third when bit 0 of the starting byte was 1, are taken as configuration words and leave the mask unchanged. Only after that does an odd write load the mask again.
- R3: An odd write in the ready state loads the mask, and an odd read returns it. A mask bit of 1 keeps its line from raising `int_out` or winning a poll.
- R4: Priority is fixed: among the qualifying lines, the lowest index wins.
- R5: `int_out` is high when an unmasked pending line has a lower index than every in-service bit, or when no bit is in service. It updates one clock after the request lines change.
- R6: The even write 0x0C arms a poll. The next even read returns 0x80 OR the winning level (level in bits 2:0, bit 7 = 1). That read sets the level's in-service bit and disarms the poll.
- R7: The even write 0x20 (bits 7:5 = 001, bits 4:3 = 00) clears only the lowest-index bit set in the in-service register.
- R8: The even write 0x0B makes even reads return the in-service register, and 0x0A makes them return the request register. Request readback is the default.
- R9: A poll read with no qualifying request returns 0x07 (bit 7 = 0, level 7) and leaves the in-service register unchanged.
- R10: The request register samples the lines every clock. A request whose line drops before it is acknowledged disappears from the register and from `int_out`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| sel_odd | input | 1 | Location select: 0 even, 1 odd |
| wr_en | input | 1 | Write strobe for one cycle |
| rd_en | input | 1 | Read strobe for one cycle |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational from the selected register while `rd_en` is high |
| irq_in | input | 8 | Level-sensitive request lines |
| int_out | output | 1 | Interrupt request to the host |

## Verification
Request lines are sampled at a clock edge, so `int_out` and the request readback reflect a change on `irq_in` one edge later. The bench changes the lines at a falling edge and checks at the next falling edge but one. Read data is combinational, so each read is sampled shortly after `rd_en` rises and before the edge at which a poll read takes effect. Any register change caused by a write or a poll acknowledge is checked through a later read, issued after the edge that performs the change.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;

  localparam int NLINES = 8;
  localparam int LVL_W  = $clog2(NLINES);

  typedef enum logic [1:0] {
    CFG_READY,
    CFG_VEC,
    CFG_CASC,
    CFG_MODE
  } cfg_state_e;

  // index of the most urgent (lowest-numbered) set bit; 0 when none
  function automatic logic [LVL_W-1:0] first_set(input logic [NLINES-1:0] v);
    logic [LVL_W-1:0] r;
    r = '0;
    for (int i = NLINES - 1; i >= 0; i--) begin
      if (v[i]) r = LVL_W'(i);
    end
    return r;
  endfunction

  // lines allowed to interrupt given the in-service set
  function automatic logic [NLINES-1:0] allowed_lines(input logic [NLINES-1:0] isr);
    logic [NLINES-1:0] m;
    logic [LVL_W-1:0]  k;
    k = first_set(isr);
    for (int i = 0; i < NLINES; i++) begin
      m[i] = (isr == '0) || (LVL_W'(i) < k);
    end
    return m;
  endfunction

  function automatic logic [NLINES-1:0] level_bit(input logic [LVL_W-1:0] lvl);
    return NLINES'(1) << lvl;
  endfunction

  // drop the most urgent in-service bit
  function automatic logic [NLINES-1:0] retire_top(input logic [NLINES-1:0] isr);
    if (isr == '0) return '0;
    return isr & ~level_bit(first_set(isr));
  endfunction

endpackage

// File: rtl/pic_cmd_decode.sv
module pic_cmd_decode
  import prio_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sel_odd,
  input  logic       wr_en,
  input  logic [7:0] wdata,
  output logic       cfg_start,
  output logic       mask_wr,
  output logic       eoi_cmd,
  output logic       poll_cmd,
  output logic       rsel_wr,
  output logic       rsel_isr,
  output cfg_state_e cfg_state
);

  logic       need_mode_q;
  logic       even_wr, odd_wr, ready;

  assign even_wr   = wr_en && !sel_odd;
  assign odd_wr    = wr_en && sel_odd;
  assign ready     = (cfg_state == CFG_READY);

  assign cfg_start = even_wr && wdata[4];
  assign mask_wr   = odd_wr && ready;
  assign eoi_cmd   = even_wr && ready && !wdata[4] && !wdata[3] && (wdata[7:5] == 3'b001);
  assign poll_cmd  = even_wr && ready && !wdata[4] && wdata[3] && wdata[2];
  assign rsel_wr   = even_wr && ready && !wdata[4] && wdata[3] && wdata[1];
  assign rsel_isr  = wdata[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_state   <= CFG_READY;
      need_mode_q <= 1'b0;
    end else if (cfg_start) begin
      cfg_state   <= CFG_VEC;
      need_mode_q <= wdata[0];
    end else if (odd_wr) begin
      case (cfg_state)
        CFG_VEC:  cfg_state <= CFG_CASC;
        CFG_CASC: cfg_state <= need_mode_q ? CFG_MODE : CFG_READY;
        CFG_MODE: cfg_state <= CFG_READY;
        default:  cfg_state <= CFG_READY;
      endcase
    end
  end

endmodule

// File: rtl/pic_prio_resolve.sv
module pic_prio_resolve
  import prio_irq_pkg::*;
(
  input  logic [NLINES-1:0] irr,
  input  logic [NLINES-1:0] mask,
  input  logic [NLINES-1:0] isr,
  output logic              req_valid,
  output logic [LVL_W-1:0]  req_lvl
);

  logic [NLINES-1:0] eligible;

  assign eligible  = irr & ~mask & allowed_lines(isr);
  assign req_valid = (eligible != '0);
  assign req_lvl   = first_set(eligible);

endmodule

// File: rtl/pic_state_regs.sv
module pic_state_regs
  import prio_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLINES-1:0] irq_in,
  input  logic [7:0]        wdata,
  input  logic              cfg_start,
  input  logic              mask_wr,
  input  logic              eoi_cmd,
  input  logic              poll_cmd,
  input  logic              rsel_wr,
  input  logic              rsel_isr,
  input  logic              even_rd,
  input  logic              ack_fire,
  input  logic [LVL_W-1:0]  ack_lvl,
  output logic [NLINES-1:0] irr_q,
  output logic [NLINES-1:0] isr_q,
  output logic [NLINES-1:0] mask_q,
  output logic              poll_armed,
  output logic              show_isr
);

  logic [NLINES-1:0] ack_bit;
  assign ack_bit = ack_fire ? level_bit(ack_lvl) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irr_q      <= '0;
      isr_q      <= '0;
      mask_q     <= '1;
      poll_armed <= 1'b0;
      show_isr   <= 1'b0;
    end else begin
      irr_q <= irq_in & ~ack_bit;

      if (cfg_start)    isr_q <= '0;
      else if (eoi_cmd) isr_q <= retire_top(isr_q);
      else              isr_q <= isr_q | ack_bit;

      if (mask_wr) mask_q <= wdata;

      if (cfg_start)     poll_armed <= 1'b0;
      else if (poll_cmd) poll_armed <= 1'b1;
      else if (even_rd)  poll_armed <= 1'b0;

      if (cfg_start)    show_isr <= 1'b0;
      else if (rsel_wr) show_isr <= rsel_isr;
    end
  end

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import prio_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sel_odd,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic [7:0] irq_in,
  output logic       int_out
);

  logic              cfg_start, mask_wr, eoi_cmd, poll_cmd, rsel_wr, rsel_isr;
  cfg_state_e        cfg_state;
  logic [NLINES-1:0] irr_q, isr_q, mask_q;
  logic              poll_armed, show_isr;
  logic              req_valid;
  logic [LVL_W-1:0]  req_lvl;

  // named events for the checker
  logic even_rd, poll_rd, ack_fire, spur_rd, eoi_fire;
  logic [7:0] poll_word;

  assign even_rd  = rd_en && !sel_odd;
  assign poll_rd  = even_rd && poll_armed;
  assign ack_fire = poll_rd && req_valid;
  assign spur_rd  = poll_rd && !req_valid;
  assign eoi_fire = eoi_cmd;

  pic_cmd_decode u_dec (
    .clk(clk), .rst_n(rst_n), .sel_odd(sel_odd), .wr_en(wr_en), .wdata(wdata),
    .cfg_start(cfg_start), .mask_wr(mask_wr), .eoi_cmd(eoi_cmd),
    .poll_cmd(poll_cmd), .rsel_wr(rsel_wr), .rsel_isr(rsel_isr),
    .cfg_state(cfg_state)
  );

  pic_prio_resolve u_res (
    .irr(irr_q), .mask(mask_q), .isr(isr_q),
    .req_valid(req_valid), .req_lvl(req_lvl)
  );

  pic_state_regs u_regs (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .wdata(wdata),
    .cfg_start(cfg_start), .mask_wr(mask_wr), .eoi_cmd(eoi_cmd),
    .poll_cmd(poll_cmd), .rsel_wr(rsel_wr), .rsel_isr(rsel_isr),
    .even_rd(even_rd), .ack_fire(ack_fire), .ack_lvl(req_lvl),
    .irr_q(irr_q), .isr_q(isr_q), .mask_q(mask_q),
    .poll_armed(poll_armed), .show_isr(show_isr)
  );

  assign poll_word = req_valid ? {1'b1, {(7-LVL_W){1'b0}}, req_lvl}
                               : {1'b0, {(7-LVL_W){1'b0}}, LVL_W'(NLINES - 1)};

  always_comb begin
    if (sel_odd)         rdata = mask_q;
    else if (poll_armed) rdata = poll_word;
    else if (show_isr)   rdata = isr_q;
    else                 rdata = irr_q;
  end

  assign int_out = req_valid;

endmodule

// File: rtl/pic_checker.sv
module pic_checker
  import prio_irq_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              cfg_start,
  input logic              mask_wr,
  input logic              eoi_fire,
  input logic              poll_rd,
  input logic              ack_fire,
  input logic              spur_rd,
  input logic [LVL_W-1:0]  ack_lvl,
  input logic [NLINES-1:0] irr_q,
  input logic [NLINES-1:0] isr_q,
  input logic [NLINES-1:0] mask_q,
  input logic              poll_armed,
  input logic              int_out
);

  AST_ACK_SETS_ISR: assert property (@(posedge clk) disable iff (!rst_n)
    ack_fire && !wr_en |=> isr_q[$past(ack_lvl)]); // R6

  AST_SPUR_NO_ISR: assert property (@(posedge clk) disable iff (!rst_n)
    spur_rd && !wr_en |=> $stable(isr_q)); // R9

  AST_EOI_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_fire && !cfg_start && !ack_fire && (isr_q != '0)
      |=> $countones(isr_q) == $countones($past(isr_q)) - 1); // R7

  AST_INT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    int_out |-> ((irr_q & ~mask_q) != '0)); // R5

  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_wr |=> $stable(mask_q)); // R3

  AST_POLL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    poll_rd && !wr_en |=> !poll_armed); // R6

endmodule

bind prio_irq_ctrl pic_checker u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .cfg_start(cfg_start),
  .mask_wr(mask_wr), .eoi_fire(eoi_fire), .poll_rd(poll_rd),
  .ack_fire(ack_fire), .spur_rd(spur_rd), .ack_lvl(req_lvl),
  .irr_q(irr_q), .isr_q(isr_q), .mask_q(mask_q),
  .poll_armed(poll_armed), .int_out(int_out)
);

// File: tb/sim_prio_irq_ctrl.sv
module sim_prio_irq_ctrl;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sel_odd = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wdata = '0, irq_in = '0;
  logic [7:0] rdata;
  logic       int_out;
  int         n_run = 0, n_fail = 0;
  bit         done = 0;

  always #2 clk = ~clk;  // 250 MHz

  prio_irq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .sel_odd(sel_odd), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .irq_in(irq_in), .int_out(int_out)
  );

  // {mask, lines, expected poll byte}
  localparam logic [23:0] VEC [8] = '{
    {8'h00, 8'h80, 8'h87}, {8'h00, 8'h81, 8'h80},
    {8'h00, 8'h0C, 8'h82}, {8'h04, 8'h0C, 8'h83},
    {8'hFF, 8'hFF, 8'h07}, {8'hF0, 8'h30, 8'h07},
    {8'h01, 8'h03, 8'h81}, {8'h7F, 8'hC0, 8'h87}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic odd, input logic [7:0] d);
    @(negedge clk);
    sel_odd = odd; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic odd, output logic [7:0] d);
    @(negedge clk);
    sel_odd = odd; rd_en = 1'b1;
    #1 d = rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic lines(input logic [7:0] v);
    @(negedge clk);
    irq_in = v;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic read_isr(output logic [7:0] d);
    wr(1'b0, 8'h0B);
    rd(1'b0, d);
    wr(1'b0, 8'h0A);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got 00 expected 01");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 int_out", {7'd0, int_out}, 8'h00);
    rd(1'b1, d);  check("R1 mask", d, 8'hFF);
    rd(1'b0, d);  check("R1 irr", d, 8'h00);
    read_isr(d);  check("R1 isr", d, 8'h00);

    // R3 R4 R5 R6 R7 R9 table walk
    foreach (VEC[i]) begin
      wr(1'b1, VEC[i][23:16]);
      lines(VEC[i][15:8]);
      check("R5 int_out", {7'd0, int_out}, {7'd0, VEC[i][7]});
      wr(1'b0, 8'h0C);
      rd(1'b0, d);
      check("R6 R4 R9 poll", d, VEC[i][7:0]);
      lines(8'h00);
      read_isr(d);
      check("R6 R9 isr after poll", d, VEC[i][7] ? (8'h01 << VEC[i][2:0]) : 8'h00);
      if (VEC[i][7]) wr(1'b0, 8'h20);
      read_isr(d);
      check("R7 isr after eoi", d, 8'h00);
    end

    // R3 mask readback
    wr(1'b1, 8'h5A);
    rd(1'b1, d); check("R3 mask readback", d, 8'h5A);

    // R5 R4 R7 nesting
    wr(1'b1, 8'h00);
    lines(8'h20);
    wr(1'b0, 8'h0C); rd(1'b0, d); check("R6 first ack", d, 8'h85);
    lines(8'h60);
    check("R5 lower level blocked", {7'd0, int_out}, 8'h00);
    lines(8'h64);
    check("R5 higher level passes", {7'd0, int_out}, 8'h01);
    wr(1'b0, 8'h0C); rd(1'b0, d); check("R4 nested ack", d, 8'h82);
    read_isr(d); check("R8 isr view", d, 8'h24);
    rd(1'b0, d); check("R8 irr view", d, 8'h64);
    wr(1'b0, 8'h20);
    read_isr(d); check("R7 clears lowest index", d, 8'h20);
    lines(8'h00);
    wr(1'b0, 8'h20);
    read_isr(d); check("R7 second eoi", d, 8'h00);

    // R10 R9 dropped request reads as spurious
    lines(8'h80);
    check("R10 raised", {7'd0, int_out}, 8'h01);
    lines(8'h00);
    check("R10 dropped int", {7'd0, int_out}, 8'h00);
    rd(1'b0, d); check("R10 irr cleared", d, 8'h00);
    wr(1'b0, 8'h0C); rd(1'b0, d); check("R9 spurious code", d, 8'h07);
    read_isr(d); check("R9 no isr bit", d, 8'h00);

    // R2 configuration with mode word
    lines(8'h08);
    wr(1'b0, 8'h0C); rd(1'b0, d); check("R2 pre ack", d, 8'h83);
    wr(1'b1, 8'h55);
    wr(1'b0, 8'h0B);
    wr(1'b0, 8'h11);
    rd(1'b0, d); check("R2 irr selected", d, 8'h08);
    wr(1'b1, 8'h20); wr(1'b1, 8'h04);
    rd(1'b1, d); check("R2 mask kept mid-seq", d, 8'h55);
    wr(1'b1, 8'h01);
    rd(1'b1, d); check("R2 mode word not mask", d, 8'h55);
    read_isr(d); check("R2 isr cleared", d, 8'h00);
    wr(1'b1, 8'hA5);
    rd(1'b1, d); check("R2 mask after seq", d, 8'hA5);

    // R2 configuration without mode word
    wr(1'b0, 8'h10);
    wr(1'b1, 8'h08); wr(1'b1, 8'h02);
    wr(1'b1, 8'h3C);
    rd(1'b1, d); check("R2 short seq mask", d, 8'h3C);
    lines(8'h00);

    // R1 reset again
    wr(1'b1, 8'h00);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    rd(1'b1, d); check("R1 mask after reset", d, 8'hFF);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule